// File: doc/BRIEF.md
# Maskable Clear-on-Read Interrupt Collector

This block gathers single-cycle event pulses from up to `NUM_SRC` interrupt sources into a sticky flag register. A flag stays set until the host reads the flag register, and that read also clears it. Two host-written registers decide whether the flags reach the interrupt pin. A per-source mask chooses which flags may assert it, and a one-bit global enable turns the pin on or off.

The interrupt pin is active low and open-drain. It is either pulled down to 0 or released to high impedance, and an external pull-up brings a released pin high. When the global enable is off the pin stays released, whatever the flags hold. A companion output, `irq_oe`, reports when the pin is being driven. The host reaches the registers through a small synchronous bus. Read data is registered and appears on the cycle after the read strobe.

Register addresses: 0 is the flag register (read clears, writes ignored), 1 is the mask, 2 is the enable (bit 0 only), and 3 is unused (reads return 0).

Top module: `irq_ctrl`

## Requirements
- R1: After reset the flags, mask, enable and read data are all 0, `irq_oe` is 0 and the pin is released.
- R2: A 1 on `src_pulse[i]` at a clock edge sets flag bit i, and the bit stays set while the flag register is not read.
- R3: A read of address 0 returns, on the next cycle, the flags held before the read, and clears every flag not re-set by a pulse in that same cycle.
- R4: A pulse that arrives in the same cycle as a flag read is not part of that read's data, and its flag remains set after the clear.
- R5: Flags record events whatever the mask and enable hold. Mask and enable act only on the pin.
- R6: While the enable is 0 the pin is released (`irq_oe` = 0) for any flag and mask contents.
- R7: While the enable is 1 and some flag bit with its mask bit set is 1, the pin is driven to 0 and `irq_oe` is 1.
- R8: While the enable is 1 and no flag bit with its mask bit set is 1, the pin is released. The block never drives the pin to 1.
- R9: Writing address 1 loads the mask and writing address 2 loads bit 0 of the data as the enable. Reading them back gives the mask, and the enable in bit 0 with the upper bits 0.
- R10: Writes to address 0 or 3 change no register, and a read of address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | NUM_SRC | Write data |
| bus_rdata | output | NUM_SRC | Registered read data |
| src_pulse | input | NUM_SRC | One-cycle event pulses, one per source |
| irq_n | output | 1 | Open-drain interrupt pin: 0 or high impedance |
| irq_oe | output | 1 | 1 while the pin is driven low |

## Verification
The hardest case to reach is a flag read in the same cycle as a new event on some source, because it depends on the exact cycle alignment of a host read and a source pulse. It also matters most when the read clears the only masked flag while the new event sets a masked bit, so the pin must stay low through the clear. Directed steps set up this alignment with the mask chosen so that the pin level depends on which flag survives. Several thousand random cycles then issue reads and pulses often enough that same-cycle collisions occur many times, with the mask and enable in varied states.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 2;
  typedef enum logic [ADDR_W-1:0] {
    A_FLAGS  = 2'd0,
    A_MASK   = 2'd1,
    A_ENABLE = 2'd2,
    A_SPARE  = 2'd3
  } irq_addr_e;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_pulse,
  input  logic               rd_clr,
  output logic [NUM_SRC-1:0] flags
);
  function automatic logic [NUM_SRC-1:0] next_flags(
    input logic [NUM_SRC-1:0] cur,
    input logic               clr,
    input logic [NUM_SRC-1:0] ev
  );
    logic [NUM_SRC-1:0] kept;
    kept = clr ? '0 : cur;
    return kept | ev;
  endfunction

  logic [NUM_SRC-1:0] flags_d;
  assign flags_d = next_flags(flags, rd_clr, src_pulse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  AST_PULSE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pulse != '0) |=> ((flags & $past(src_pulse)) == $past(src_pulse))); // R2
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((flags & $past(flags)) == $past(flags))); // R2
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((flags & ~$past(src_pulse)) == '0)); // R3
  AST_COLLIDE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && src_pulse != '0) |=> (flags == $past(src_pulse))); // R4
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_mask,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] mask_q,
  output logic               en_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      if (wr_en)   en_q   <= wdata[0];
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q)); // R10
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q)); // R10
endmodule

// File: rtl/irq_read_port.sv
module irq_read_port #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_stb,
  input  irq_pkg::irq_addr_e addr,
  input  logic [NUM_SRC-1:0] flags,
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic               en_q,
  output logic [NUM_SRC-1:0] rdata
);
  import irq_pkg::*;

  logic [NUM_SRC-1:0] sel_val;

  always_comb begin
    sel_val = '0;
    unique case (addr)
      A_FLAGS:  sel_val = flags;
      A_MASK:   sel_val = mask_q;
      A_ENABLE: sel_val[0] = en_q;
      A_SPARE:  sel_val = '0;
      default:  sel_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_stb) rdata <= sel_val;
  end

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rdata)); // R3
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && addr == A_SPARE) |=> (rdata == '0)); // R10
endmodule

// File: rtl/irq_od_driver.sv
module irq_od_driver #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] flags,
  input  logic [NUM_SRC-1:0] mask_q,
  input  logic               en_q,
  output logic               drive_low
);
  logic [NUM_SRC-1:0] live;
  assign live      = flags & mask_q;
  assign drive_low = en_q & (|live);
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [1:0]         bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] src_pulse,
  output wire                irq_n,
  output logic               irq_oe
);
  import irq_pkg::*;

  irq_addr_e          addr;
  logic               rd_stb, wr_stb, rd_flags, wr_mask, wr_en;
  logic [NUM_SRC-1:0] flags, mask_q;
  logic               en_q, drive_low;

  assign addr     = irq_addr_e'(bus_addr);
  assign rd_stb   = bus_sel & ~bus_wr;
  assign wr_stb   = bus_sel & bus_wr;
  assign rd_flags = rd_stb & (addr == A_FLAGS);
  assign wr_mask  = wr_stb & (addr == A_MASK);
  assign wr_en    = wr_stb & (addr == A_ENABLE);

  irq_flag_bank #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse),
    .rd_clr(rd_flags), .flags(flags));

  irq_cfg_regs #(.NUM_SRC(NUM_SRC)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_mask(wr_mask), .wr_en(wr_en),
    .wdata(bus_wdata), .mask_q(mask_q), .en_q(en_q));

  irq_read_port #(.NUM_SRC(NUM_SRC)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .addr(addr),
    .flags(flags), .mask_q(mask_q), .en_q(en_q), .rdata(bus_rdata));

  irq_od_driver #(.NUM_SRC(NUM_SRC)) u_od (
    .flags(flags), .mask_q(mask_q), .en_q(en_q), .drive_low(drive_low));

  assign irq_n  = drive_low ? 1'b0 : 1'bz;
  assign irq_oe = drive_low;

  AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !irq_oe); // R6
  AST_EVENT_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !wr_mask && !wr_en && (src_pulse & mask_q) != '0) |=> irq_oe); // R7
  AST_QUIET_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_flags && src_pulse == '0 && !wr_mask && !wr_en) |=> !irq_oe); // R8
  AST_READ_RETURNS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flags |=> (bus_rdata == $past(flags))); // R3
endmodule

// File: tb/irq_ctrl_test.sv
module irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, src_pulse = '0;
  logic [7:0] bus_rdata;
  logic       irq_oe;
  wire        irq_line;

  pullup (irq_line);

  irq_ctrl #(.NUM_SRC(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_pulse(src_pulse), .irq_n(irq_line), .irq_oe(irq_oe));

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_flags = '0, m_mask = '0, m_rdata = '0;
  logic       m_en = 1'b0;
  logic       done = 1'b0;

  function automatic logic m_drive(input logic [7:0] f, input logic [7:0] m, input logic e);
    return e && ((f & m) != 8'h00);
  endfunction

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_flags;
      2'd1: return m_mask;
      2'd2: return {7'b0, m_en};
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic d;
    d = m_drive(m_flags, m_mask, m_en);
    chk(tag, "rdata", bus_rdata, m_rdata);
    chk(tag, "irq_oe", {7'b0, irq_oe}, {7'b0, d});
    chk(tag, "pin", {7'b0, irq_line}, {7'b0, ~d});
  endtask

  task automatic step(input string tag, input logic s, input logic w, input logic [1:0] a,
                      input logic [7:0] d, input logic [7:0] p);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; src_pulse = p;
    @(posedge clk);
    if (s && !w) m_rdata = m_read(a);
    m_flags = ((s && !w && a == 2'd0) ? 8'h00 : m_flags) | p;
    if (s && w && a == 2'd1) m_mask = d;
    if (s && w && a == 2'd2) m_en = d[0];
    @(negedge clk);
    bus_sel = 1'b0; src_pulse = '0;
    check_all(tag);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    step("R1", 1, 0, 2'd1, 8'h00, 8'h00);
    step("R1", 1, 0, 2'd2, 8'h00, 8'h00);
    // R5 / R6: events captured while masked off and disabled, pin stays released
    step("R5", 0, 0, 2'd0, 8'h00, 8'h05);
    step("R6", 0, 0, 2'd0, 8'h00, 8'h40);
    // R2 / R3: read returns sticky flags, second read sees them cleared
    step("R2", 1, 0, 2'd0, 8'h00, 8'h00);
    chk("R2", "read flags", bus_rdata, 8'h45);
    step("R3", 1, 0, 2'd0, 8'h00, 8'h00);
    chk("R3", "cleared", bus_rdata, 8'h00);
    // R9: mask and enable load and read back, upper enable bits 0
    step("R9", 1, 1, 2'd1, 8'hF0, 8'h00);
    step("R9", 1, 1, 2'd2, 8'hFF, 8'h00);
    step("R9", 1, 0, 2'd2, 8'h00, 8'h00);
    chk("R9", "enable readback", bus_rdata, 8'h01);
    step("R9", 1, 0, 2'd1, 8'h00, 8'h00);
    chk("R9", "mask readback", bus_rdata, 8'hF0);
    // R8: enabled, unmasked source only, pin released
    step("R8", 0, 0, 2'd0, 8'h00, 8'h01);
    chk("R8", "oe", {7'b0, irq_oe}, 8'h00);
    // R7: masked source pulls the pin low
    step("R7", 0, 0, 2'd0, 8'h00, 8'h10);
    chk("R7", "pin", {7'b0, irq_line}, 8'h00);
    // R4: read collides with a new masked event; pin stays low after clear
    step("R4", 1, 0, 2'd0, 8'h00, 8'h20);
    chk("R4", "read excludes new", bus_rdata, 8'h11);
    chk("R4", "pin held", {7'b0, irq_line}, 8'h00);
    step("R4", 1, 0, 2'd0, 8'h00, 8'h00);
    chk("R4", "kept flag", bus_rdata, 8'h20);
    chk("R8", "released after read", {7'b0, irq_oe}, 8'h00);
    // R10: writes to flags and spare addresses ignored
    step("R10", 0, 0, 2'd0, 8'h00, 8'h80);
    step("R10", 1, 1, 2'd0, 8'h00, 8'h00);
    step("R10", 1, 1, 2'd3, 8'hAA, 8'h00);
    step("R10", 1, 0, 2'd3, 8'h00, 8'h00);
    chk("R10", "spare reads 0", bus_rdata, 8'h00);
    chk("R10", "flags survive write", {7'b0, irq_oe}, 8'h01);
    step("R10", 1, 0, 2'd0, 8'h00, 8'h00);
    chk("R10", "flag bit intact", bus_rdata, 8'h80);
    // R6: disabling releases a pending masked flag
    step("R6", 0, 0, 2'd0, 8'h00, 8'h30);
    step("R6", 1, 1, 2'd2, 8'h00, 8'h00);
    chk("R6", "pin released", {7'b0, irq_line}, 8'h01);
    // Random mix covering R2..R10
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] op;
      logic [7:0] p;
      op = 4'($urandom_range(0, 15));
      p  = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h00;
      if (op < 4)       step("RND", 1, 0, 2'd0, 8'h00, p);
      else if (op < 6)  step("RND", 1, 1, 2'd1, 8'($urandom), p);
      else if (op < 7)  step("RND", 1, 1, 2'd2, 8'($urandom), p);
      else if (op < 9)  step("RND", 1, 0, 2'($urandom), 8'h00, p);
      else if (op < 10) step("RND", 1, 1, 2'(($urandom & 1) * 3), 8'($urandom), p);
      else              step("RND", 0, 0, 2'd0, 8'h00, p);
    end
    done = 1'b1;
    summary();
  end
endmodule